// File: doc/BRIEF.md
# Streaming Bounding-Box Completion Detector

This block runs next to a raster-order pixel labeler. Each cycle it receives one pixel: whether it is foreground or background, its label, the labels of the left, upper-left and upper neighbours, and the pixel's column and row. From this stream it keeps the extent of every label in a coordinate table. It also keeps a small per-label cache of the column where the label's most recent run ended.

A particular neighbour pattern shows that a region may have just finished. The pattern is a background pixel whose upper-left neighbour is labelled while its upper and left neighbours are background. When the pattern appears, the block queues a check on the upper-left label. A two-cycle check state machine reads both tables for that label. It reports the box when the current position lies below the label's lowest row and to the right of its last cached column.

Finished boxes leave the block as a valid/ready stream. Each box is reported as soon as it is known to be complete, not at the end of the frame. Label allocation and the joining of boxes across image slices are handled elsewhere.

Top module: `bbx_done_det`

## Requirements
- R1: After reset `box_vld` is low and both tables are empty, so a label used again after reset reports only the pixels seen since that reset.
- R2: Every valid foreground pixel with a nonzero label widens that label's entry to include its column and row. This holds also when consecutive pixels carry the same label, where the stored minimum must keep the first pixel of the run.
- R3: A check starts only for a valid background pixel whose upper-left label is nonzero and whose upper and left labels are both zero. The label checked is the upper-left one, and a reported label is never zero.
- R4: A check reports its label only when the checking pixel's row is strictly greater than the label's stored maximum row.
- R5: A valid background pixel with a nonzero left label stores (column − 1) into the column cache at that left label. A check reports only when the checking pixel's column is strictly greater than the cached column for the checked label.
- R6: A reported box carries the checked label and the stored minimum column, maximum column, minimum row and maximum row, with min ≤ max on both axes.
- R7: With the trigger queue empty, the checker idle and the output free, `box_vld` rises at the third rising clock edge, counting the edge that samples the triggering pixel.
- R8: While `box_vld` is high and `box_rdy` is low, `box_vld` and all box fields hold their values.
- R9: Up to two pending checks wait in a queue and are handled in arrival order. A trigger that arrives while the queue is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel present this cycle |
| pix_fg | input | 1 | 1 = foreground, 0 = background |
| pix_lbl | input | LBL_W | Label of the current pixel (0 = none) |
| nbr_left | input | LBL_W | Label of the left neighbour |
| nbr_upleft | input | LBL_W | Label of the upper-left neighbour |
| nbr_up | input | LBL_W | Label of the upper neighbour |
| pix_col | input | X_W | Column of the current pixel |
| pix_row | input | Y_W | Row of the current pixel |
| box_vld | output | 1 | A completed box is offered |
| box_rdy | input | 1 | Downstream accepts the box |
| box_lbl | output | LBL_W | Label of the completed box |
| box_min_x | output | X_W | Leftmost column |
| box_max_x | output | X_W | Rightmost column |
| box_min_y | output | Y_W | Top row |
| box_max_y | output | Y_W | Bottom row |

## Verification
The bench feeds a two-pixel run of one label. A table update without read-after-write forwarding overwrites the first pixel and reports a minimum column one too high. It also builds shapes where the checked label still occupies the current row, or where its earlier run ended to the right of the checking pixel. A detector that skips either comparison reports those boxes too early and emits an extra box. Finally, the bench stalls the output while five regions finish in one row. A faulty design would then change the held box, reorder the queued checks, or accept a fifth check past the two-entry queue.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

   // check state machine: idle waits for a queued trigger, cmp evaluates it
   typedef enum logic [0:0] {
      CHK_IDLE = 1'b0,
      CHK_CMP  = 1'b1
   } chk_st_e;

endpackage

// File: rtl/bbx_ram.sv
// Register-file table: one write port, NRD registered read ports,
// read-during-write to the same address returns the new word.
module bbx_ram #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   parameter int NRD   = 1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [AW-1:0]              wa,
   input  logic [WIDTH-1:0]           wd,
   input  logic [NRD-1:0][AW-1:0]     ra,
   output logic [NRD-1:0][WIDTH-1:0]  rd
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("bbx_ram: DEPTH must be a power of two, at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("bbx_ram: NRD must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wa] <= wd;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      always_ff @(posedge clk) begin
         if (!rst_n)                  rd[g] <= '0;
         else if (we && wa == ra[g])  rd[g] <= wd;
         else                         rd[g] <= mem[ra[g]];
      end
   end

endmodule

// File: rtl/bbx_trig_q.sv
// Small FIFO for pending completion checks; pushes while full are dropped.
module bbx_trig_q #(
   parameter int DEPTH = 2,
   parameter int WIDTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("bbx_trig_q: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] slot [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    n;
   logic             do_push, do_pop;

   assign empty   = (n == '0);
   assign full    = (n == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slot[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         n  <= '0;
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else begin
         if (do_push) begin
            slot[wp] <= din;
            wp       <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         end
         if (do_pop) begin
            rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   n <= n + 1'b1;
            2'b01:   n <= n - 1'b1;
            default: n <= n;
         endcase
      end
   end

endmodule

// File: rtl/bbx_done_det.sv
module bbx_done_det
   import bbx_pkg::*;
#(
   parameter int LBL_W  = 4,
   parameter int X_W    = 6,
   parameter int Y_W    = 6,
   parameter int QDEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_vld,
   input  logic             pix_fg,
   input  logic [LBL_W-1:0] pix_lbl,
   input  logic [LBL_W-1:0] nbr_left,
   input  logic [LBL_W-1:0] nbr_upleft,
   input  logic [LBL_W-1:0] nbr_up,
   input  logic [X_W-1:0]   pix_col,
   input  logic [Y_W-1:0]   pix_row,
   output logic             box_vld,
   input  logic             box_rdy,
   output logic [LBL_W-1:0] box_lbl,
   output logic [X_W-1:0]   box_min_x,
   output logic [X_W-1:0]   box_max_x,
   output logic [Y_W-1:0]   box_min_y,
   output logic [Y_W-1:0]   box_max_y
);

   if (LBL_W < 1 || LBL_W > 10) begin : g_bad_lbl
      $error("bbx_done_det: LBL_W out of range 1..10");
   end
   if (X_W < 1 || Y_W < 1) begin : g_bad_xy
      $error("bbx_done_det: coordinate widths must be positive");
   end

   localparam int NLBL = 1 << LBL_W;

   typedef struct packed {
      logic           vld;
      logic [X_W-1:0] min_x;
      logic [X_W-1:0] max_x;
      logic [Y_W-1:0] min_y;
      logic [Y_W-1:0] max_y;
   } coord_t;

   typedef struct packed {
      logic           vld;
      logic [X_W-1:0] col;
   } lastcol_t;

   typedef struct packed {
      logic [LBL_W-1:0] lbl;
      logic [X_W-1:0]   col;
      logic [Y_W-1:0]   row;
   } trig_t;

   localparam int CRD_W = $bits(coord_t);
   localparam int LC_W  = $bits(lastcol_t);
   localparam int TRG_W = $bits(trig_t);

   // ---------------- extent update pipeline (read, then merge + write)
   logic             s1_we;
   logic [LBL_W-1:0] s1_lbl;
   logic [X_W-1:0]   s1_x;
   logic [Y_W-1:0]   s1_y;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_we  <= 1'b0;
         s1_lbl <= '0;
         s1_x   <= '0;
         s1_y   <= '0;
      end else begin
         s1_we  <= pix_vld && pix_fg && (pix_lbl != '0);
         s1_lbl <= pix_lbl;
         s1_x   <= pix_col;
         s1_y   <= pix_row;
      end
   end

   chk_st_e           chk_state;
   logic [LBL_W-1:0]  chk_lbl;
   logic [X_W-1:0]    chk_col;
   logic [Y_W-1:0]    chk_row;
   logic [LBL_W-1:0]  chk_addr;
   trig_t             q_head;
   logic              q_empty, q_full, q_pop, q_push;

   logic [1:0][LBL_W-1:0] c_ra;
   logic [1:0][CRD_W-1:0] c_rd;
   coord_t                c_old, c_chk, c_new;

   assign c_ra[0] = pix_lbl;
   assign c_ra[1] = chk_addr;
   assign c_old   = c_rd[0];
   assign c_chk   = c_rd[1];

   always_comb begin
      c_new = c_old;
      if (!c_old.vld) begin
         c_new = '{vld: 1'b1, min_x: s1_x, max_x: s1_x, min_y: s1_y, max_y: s1_y};
      end else begin
         if (s1_x < c_old.min_x) c_new.min_x = s1_x;
         if (s1_x > c_old.max_x) c_new.max_x = s1_x;
         if (s1_y < c_old.min_y) c_new.min_y = s1_y;
         if (s1_y > c_old.max_y) c_new.max_y = s1_y;
      end
   end

   bbx_ram #(.DEPTH(NLBL), .WIDTH(CRD_W), .NRD(2)) u_coord (
      .clk (clk),
      .rst_n (rst_n),
      .we  (s1_we),
      .wa  (s1_lbl),
      .wd  (c_new),
      .ra  (c_ra),
      .rd  (c_rd)
   );

   // ---------------- last-column cache, written at the left label
   logic                  k_we;
   lastcol_t              k_wd, k_chk;
   logic [0:0][LBL_W-1:0] k_ra;
   logic [0:0][LC_W-1:0]  k_rd;

   assign k_we    = pix_vld && !pix_fg && (nbr_left != '0);
   assign k_wd    = '{vld: 1'b1, col: pix_col - 1'b1};
   assign k_ra[0] = chk_addr;
   assign k_chk   = k_rd[0];

   bbx_ram #(.DEPTH(NLBL), .WIDTH(LC_W), .NRD(1)) u_lastcol (
      .clk (clk),
      .rst_n (rst_n),
      .we  (k_we),
      .wa  (nbr_left),
      .wd  (k_wd),
      .ra  (k_ra),
      .rd  (k_rd)
   );

   // ---------------- trigger detection and queue
   trig_t q_din;
   assign q_push = pix_vld && !pix_fg && (nbr_upleft != '0) &&
                   (nbr_up == '0) && (nbr_left == '0);
   assign q_din  = '{lbl: nbr_upleft, col: pix_col, row: pix_row};

   logic [TRG_W-1:0] q_dout;
   assign q_head = q_dout;

   bbx_trig_q #(.DEPTH(QDEPTH), .WIDTH(TRG_W)) u_trigq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (q_din),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   // ---------------- check state machine
   logic chk_hit, out_free, box_load;

   assign chk_addr = (chk_state == CHK_CMP) ? chk_lbl : q_head.lbl;
   assign q_pop    = (chk_state == CHK_IDLE) && !q_empty;
   assign chk_hit  = c_chk.vld && (!k_chk.vld || (chk_col > k_chk.col)) &&
                     (chk_row > c_chk.max_y);
   assign out_free = !box_vld || box_rdy;
   assign box_load = (chk_state == CHK_CMP) && chk_hit && out_free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_state <= CHK_IDLE;
         chk_lbl   <= '0;
         chk_col   <= '0;
         chk_row   <= '0;
      end else begin
         case (chk_state)
            CHK_IDLE: if (q_pop) begin
               chk_state <= CHK_CMP;
               chk_lbl   <= q_head.lbl;
               chk_col   <= q_head.col;
               chk_row   <= q_head.row;
            end
            default: if (!chk_hit || out_free) chk_state <= CHK_IDLE;
         endcase
      end
   end

   // ---------------- output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         box_vld   <= 1'b0;
         box_lbl   <= '0;
         box_min_x <= '0;
         box_max_x <= '0;
         box_min_y <= '0;
         box_max_y <= '0;
      end else begin
         if (box_vld && box_rdy) box_vld <= 1'b0;
         if (box_load) begin
            box_vld   <= 1'b1;
            box_lbl   <= chk_lbl;
            box_min_x <= c_chk.min_x;
            box_max_x <= c_chk.max_x;
            box_min_y <= c_chk.min_y;
            box_max_y <= c_chk.max_y;
         end
      end
   end

endmodule

// File: rtl/bbx_done_det_chk.sv
module bbx_done_det_chk
   import bbx_pkg::*;
#(
   parameter int LBL_W = 4,
   parameter int X_W   = 6,
   parameter int Y_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             box_vld,
   input logic             box_rdy,
   input logic [LBL_W-1:0] box_lbl,
   input logic [X_W-1:0]   box_min_x,
   input logic [X_W-1:0]   box_max_x,
   input logic [Y_W-1:0]   box_min_y,
   input logic [Y_W-1:0]   box_max_y,
   input chk_st_e          chk_state,
   input logic [Y_W-1:0]   chk_row
);

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (box_vld && !box_rdy) |=> (box_vld && $stable(box_lbl) && $stable(box_min_x) &&
       $stable(box_max_x) && $stable(box_min_y) && $stable(box_max_y))); // R8

   AST_BOX_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
      box_vld |-> (box_min_x <= box_max_x && box_min_y <= box_max_y)); // R6

   AST_LBL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      box_vld |-> (box_lbl != '0)); // R3

   AST_LOAD_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(box_vld) |-> ($past(chk_state) == CHK_CMP)); // R7

   AST_BELOW_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(box_vld) |-> (box_max_y < $past(chk_row))); // R4

endmodule

bind bbx_done_det bbx_done_det_chk #(.LBL_W(LBL_W), .X_W(X_W), .Y_W(Y_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .box_vld   (box_vld),
   .box_rdy   (box_rdy),
   .box_lbl   (box_lbl),
   .box_min_x (box_min_x),
   .box_max_x (box_max_x),
   .box_min_y (box_min_y),
   .box_max_y (box_max_y),
   .chk_state (chk_state),
   .chk_row   (chk_row)
);

// File: tb/bbx_done_det_bench.sv
`timescale 1ns/100ps
module bbx_done_det_bench;

   localparam int LBL_W = 4;
   localparam int X_W   = 6;
   localparam int Y_W   = 6;
   localparam int IW    = 16;
   localparam int IH    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pix_vld = 1'b0, pix_fg = 1'b0, box_rdy = 1'b1;
   logic [LBL_W-1:0] pix_lbl = '0, nbr_left = '0, nbr_upleft = '0, nbr_up = '0;
   logic [X_W-1:0]   pix_col = '0;
   logic [Y_W-1:0]   pix_row = '0;
   logic             box_vld;
   logic [LBL_W-1:0] box_lbl;
   logic [X_W-1:0]   box_min_x, box_max_x;
   logic [Y_W-1:0]   box_min_y, box_max_y;

   always #2.5 clk = ~clk;

   bbx_done_det #(.LBL_W(LBL_W), .X_W(X_W), .Y_W(Y_W)) u_bbx_done_det (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_fg(pix_fg), .pix_lbl(pix_lbl),
      .nbr_left(nbr_left), .nbr_upleft(nbr_upleft), .nbr_up(nbr_up),
      .pix_col(pix_col), .pix_row(pix_row), .box_vld(box_vld), .box_rdy(box_rdy),
      .box_lbl(box_lbl), .box_min_x(box_min_x), .box_max_x(box_max_x),
      .box_min_y(box_min_y), .box_max_y(box_max_y));

   int n_chk = 0, n_err = 0;
   int cyc = 0, first_vld = -1, watch_cyc = -1;
   int lg_n = 0;
   logic [LBL_W-1:0] lg_lbl [16];
   logic [X_W-1:0]   lg_x0 [16], lg_x1 [16];
   logic [Y_W-1:0]   lg_y0 [16], lg_y1 [16];
   logic [LBL_W-1:0] img [IH][IW];
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // accepted-box logger, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && box_vld) begin
         if (first_vld < 0) first_vld = cyc;
         if (box_rdy && lg_n < 16) begin
            lg_lbl[lg_n] = box_lbl;
            lg_x0[lg_n]  = box_min_x;
            lg_x1[lg_n]  = box_max_x;
            lg_y0[lg_n]  = box_min_y;
            lg_y1[lg_n]  = box_max_y;
            lg_n++;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_img();
      for (int r = 0; r < IH; r++)
         for (int c = 0; c < IW; c++) img[r][c] = '0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; pix_vld = 1'b0; box_rdy = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      lg_n = 0; first_vld = -1; watch_cyc = -1;
   endtask

   task automatic scan(input int nrows, input int wr, input int wc);
      for (int r = 0; r < nrows; r++) begin
         for (int c = 0; c < IW; c++) begin
            @(posedge clk); #1;
            pix_vld    = 1'b1;
            pix_fg     = (img[r][c] != '0);
            pix_lbl    = img[r][c];
            nbr_left   = (c > 0) ? img[r][c-1] : '0;
            nbr_up     = (r > 0) ? img[r-1][c] : '0;
            nbr_upleft = (r > 0 && c > 0) ? img[r-1][c-1] : '0;
            pix_col    = X_W'(c);
            pix_row    = Y_W'(r);
            if (r == wr && c == wc) watch_cyc = cyc;
         end
      end
      @(posedge clk); #1;
      pix_vld = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check("R1 box_vld after reset", box_vld, 0);
   endtask

   // two-pixel runs of one label: forwarding, row guard, latency
   task automatic t_single();
      do_reset();
      clear_img();
      img[0][2] = 1; img[0][3] = 1;
      img[1][1] = 1; img[1][2] = 1;
      scan(3, 2, 3);
      repeat (8) @(posedge clk);
      @(negedge clk);
      check("R4 one box only (row guard)", lg_n, 1);
      check("R3 checked label", lg_lbl[0], 1);
      check("R2 min_x kept across same-label run", lg_x0[0], 1);
      check("R6 max_x", lg_x1[0], 3);
      check("R6 min_y", lg_y0[0], 0);
      check("R6 max_y", lg_y1[0], 1);
      check("R7 latency edges", first_vld - watch_cyc, 3);
   endtask

   // earlier gap in the previous row must not finish the box
   task automatic t_cache();
      do_reset();
      clear_img();
      img[0][1] = 1; img[0][4] = 1; img[0][5] = 1;
      scan(2, -1, -1);
      repeat (8) @(posedge clk);
      @(negedge clk);
      check("R5 one box only (column guard)", lg_n, 1);
      check("R5 max_x", lg_x1[0], 5);
      check("R1 max_y fresh after reset", lg_y1[0], 0);
      check("R2 min_x", lg_x0[0], 1);
   endtask

   // five boxes finish under backpressure
   task automatic t_stall();
      logic [X_W-1:0] hx0;
      logic [Y_W-1:0] hy1;
      do_reset();
      clear_img();
      for (int k = 0; k < 5; k++) img[0][1 + 3*k] = LBL_W'(k + 1);
      box_rdy = 1'b0;
      scan(2, -1, -1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 held valid", box_vld, 1);
      check("R8 held label", box_lbl, 1);
      hx0 = box_min_x; hy1 = box_max_y;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R8 stays valid", box_vld, 1);
      check("R8 label stable", box_lbl, 1);
      check("R8 min_x stable", box_min_x, hx0);
      check("R8 max_y stable", box_max_y, hy1);
      @(posedge clk); #1;
      box_rdy = 1'b1;
      repeat (12) @(posedge clk);
      @(negedge clk);
      check("R9 fifth trigger dropped", lg_n, 4);
      for (int k = 0; k < 4; k++) begin
         check($sformatf("R9 order slot %0d", k), lg_lbl[k], k + 1);
         check($sformatf("R6 min_x slot %0d", k), lg_x0[k], 1 + 3*k);
      end
      check("R8 idle after drain", box_vld, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single();
      t_cache();
      t_stall();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule